// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. It runs from a clock at eight times the bit rate. A falling line is first checked as a possible start bit. If it stays low for several samples, the receiver waits through a short settle period. It then gathers eight data bits, least significant bit first, each sampled once per bit period. The start and stop positions are removed, so only the data byte reaches the parallel output. A one-clock strobe marks the byte, and a flag reports a stop position that was read as 0.

The serial input goes through a two-flop synchroniser before anything samples it. An enable input, driven high when the link is in asynchronous mode, gates the receiver. When it is low, the receiver stays in or returns to its idle state.

The machine has four states:
- `ST_IDLE` waits for a low line.
- `ST_QUALIFY` needs three more low samples after the first. Any high sample sends it back to `ST_IDLE`.
- `ST_SETTLE` lasts four clocks and then moves to `ST_SAMPLE`.
- `ST_SAMPLE` runs a mod-8 tick counter. On tick 7 it takes one bit. After eight data bits, the next tick 7 reads the stop position, delivers the byte and returns to `ST_IDLE`.

Dropping the enable in any active state moves the machine to `ST_IDLE`.

Top module: `ovs_async_rx`

## Requirements
- R1: While reset is low, and on the first clock after its release, `rx_data` is 0x00, and `rx_valid` and `rx_ferr` are 0.
- R2: A line held high causes no delivery.
- R3: A start is accepted only after four consecutive low samples of the synchronised line. A low pulse of three clocks is dropped with no delivery. A low pulse of exactly four clocks followed by high line is received as the byte 0xFF with `rx_ferr` 0.
- R4: A frame sent as one low start bit, eight data bits in LSB-first order and a stop bit, each held for eight clocks, is delivered on `rx_data` with bit 0 equal to the first data bit.
- R5: The stop position is sampled once. A 0 there sets `rx_ferr` to 1 for that byte, and a 1 clears it. The byte is delivered either way.
- R6: `rx_valid` is high for exactly one clock per delivered byte.
- R7: Frames sent back to back, with no idle time between a stop bit and the next start bit, are each delivered, in order.
- R8: While `rx_en` is low, the receiver stays idle and delivers nothing. Dropping `rx_en` during a frame abandons that frame. After `rx_en` returns high, the next frame is received normally.
- R9: `rx_data` and `rx_ferr` change only in the clock where `rx_valid` is high. Between deliveries they hold the last delivered values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock at eight times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable, high in asynchronous mode |
| rxd | input | 1 | Serial line, idles high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe when a byte is delivered |
| rx_ferr | output | 1 | Stop position of the last byte was read as 0 |

## Verification
A tick counter in the wrong place moves every capture point by the same amount. Within one frame this shows at the ports as a byte that differs from the one sent, usually shifted by one bit, or as a false framing flag. A start check of the wrong length shows at once: a three-clock glitch produces a stray 0xFF byte, or a four-clock glitch produces nothing. A stuck bit count or state shows as a missing or doubled strobe within about ninety clocks of the start edge.

// File: rtl/ovsrx_pkg.sv
package ovsrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_QUALIFY  = 2'd1,
        ST_SETTLE   = 2'd2,
        ST_SAMPLE   = 2'd3
    } rx_state_e;

endpackage

// File: rtl/ovsrx_sync.sv
module ovsrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ovsrx_shift.sv
module ovsrx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] sh_q;

    // First bit in ends at position 0 after WIDTH shifts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {bit_in, sh_q[WIDTH-1:1]};
    end

    assign word = sh_q;
endmodule

// File: rtl/ovsrx_ctrl.sv
module ovsrx_ctrl
    import ovsrx_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int OVS          = 8,
    parameter int QUAL_SAMPLES = 4,
    parameter int SETTLE_CLKS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rx_bit,
    input  logic [DATA_BITS-1:0] word,
    output logic                 shift_en,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o,
    output rx_state_e            state_o
);
    localparam int MAXC = (OVS > QUAL_SAMPLES) ?
                          ((OVS > SETTLE_CLKS) ? OVS : SETTLE_CLKS) :
                          ((QUAL_SAMPLES > SETTLE_CLKS) ? QUAL_SAMPLES : SETTLE_CLKS);
    localparam int TW   = $clog2(MAXC) + 1;
    localparam int BW   = $clog2(DATA_BITS + 1);

    localparam logic [TW-1:0] QUAL_LAST   = TW'(QUAL_SAMPLES - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CLKS - 1);
    localparam logic [TW-1:0] TICK_LAST   = TW'(OVS - 1);
    localparam logic [BW-1:0] BITS_FULL   = BW'(DATA_BITS);

    rx_state_e      state_q, state_d;
    logic [TW-1:0]  tick_q, tick_d;
    logic [BW-1:0]  bits_q, bits_d;
    logic           deliver;

    always_comb begin
        state_d  = state_q;
        tick_d   = tick_q;
        bits_d   = bits_q;
        shift_en = 1'b0;
        deliver  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tick_d = '0;
                bits_d = '0;
                if (en && !rx_bit) begin
                    state_d = ST_QUALIFY;
                    tick_d  = TW'(1);
                end
            end
            ST_QUALIFY: begin
                if (!en || rx_bit) begin
                    state_d = ST_IDLE;
                end else if (tick_q == QUAL_LAST) begin
                    state_d = ST_SETTLE;
                    tick_d  = '0;
                end else begin
                    tick_d = tick_q + TW'(1);
                end
            end
            ST_SETTLE: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (tick_q == SETTLE_LAST) begin
                    state_d = ST_SAMPLE;
                    tick_d  = '0;
                end else begin
                    tick_d = tick_q + TW'(1);
                end
            end
            ST_SAMPLE: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (tick_q == TICK_LAST) begin
                    tick_d = '0;
                    if (bits_q == BITS_FULL) begin
                        deliver = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        shift_en = 1'b1;
                        bits_d   = bits_q + BW'(1);
                    end
                end else begin
                    tick_d = tick_q + TW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
            bits_q  <= bits_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= deliver;
            if (deliver) begin
                data_o <= word;
                ferr_o <= !rx_bit;
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/ovs_async_rx.sv
module ovs_async_rx
    import ovsrx_pkg::*;
#(
    parameter int DATA_BITS    = 8,
    parameter int OVS          = 8,
    parameter int QUAL_SAMPLES = 4,
    parameter int SETTLE_CLKS  = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_ferr
);
    logic                 rx_s;
    logic                 shift_en;
    logic [DATA_BITS-1:0] word;
    logic [DATA_BITS-1:0] data_w;
    rx_state_e            state_w;

    ovsrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    ovsrx_shift #(.WIDTH(DATA_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (rx_s),
        .word    (word)
    );

    ovsrx_ctrl #(
        .DATA_BITS   (DATA_BITS),
        .OVS         (OVS),
        .QUAL_SAMPLES(QUAL_SAMPLES),
        .SETTLE_CLKS (SETTLE_CLKS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .rx_bit  (rx_s),
        .word    (word),
        .shift_en(shift_en),
        .data_o  (data_w),
        .valid_o (rx_valid),
        .ferr_o  (rx_ferr),
        .state_o (state_w)
    );

    assign rx_data = data_w[7:0];
endmodule

// File: rtl/ovsrx_chk.sv
module ovsrx_chk
    import ovsrx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rx_s,
    input rx_state_e  state,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ferr
);
    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    // R9
    ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_ferr));

    // R8
    en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE && !rx_valid));

    // R3
    qual_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && rx_s) |=> state == ST_IDLE);

    // R4
    deliver_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state) == ST_SAMPLE && state == ST_IDLE));
endmodule

bind ovs_async_rx ovsrx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .rx_s    (rx_s),
    .state   (state_w),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_ferr (rx_ferr)
);

// File: tb/sim_ovs_async_rx.sv
`timescale 1ns/1ps
module sim_ovs_async_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ferr;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int wide = 0;
    logic       prev_v = 1'b0;
    logic [7:0] log_d [0:3];
    logic       log_f [0:3];

    always #2 clk = ~clk;

    ovs_async_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                log_d[pulses % 4] <= rx_data;
                log_f[pulses % 4] <= rx_ferr;
                pulses <= pulses + 1;
                if (prev_v) wide <= wide + 1;
            end
            prev_v <= rx_valid;
        end
    end

    function automatic logic exp_ferr(input logic stop_bit);
        return !stop_bit;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_bit);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (8) @(negedge clk);
        end
        rxd = stop_bit;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame_check(input logic [7:0] b, input logic stop_bit, input string req);
        int p0;
        p0 = pulses;
        send(b, stop_bit);
        idle(24);
        check(pulses == p0 + 1, req, pulses - p0, 1);
        check(log_d[p0 % 4] == b, req, log_d[p0 % 4], b);
        check(log_f[p0 % 4] == exp_ferr(stop_bit), req, log_f[p0 % 4], exp_ferr(stop_bit));
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p0;
        logic [7:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 during reset
        check(rx_data == 8'h00 && !rx_valid && !rx_ferr, "R1", {rx_valid, rx_ferr, rx_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_data == 8'h00 && !rx_valid && !rx_ferr, "R1", {rx_valid, rx_ferr, rx_data}, 0);
        rx_en = 1'b1;

        // R2 idle line
        p0 = pulses;
        idle(200);
        check(pulses == p0, "R2", pulses - p0, 0);

        // R4 directed patterns, R5 clean stop
        frame_check(8'h55, 1'b1, "R4");
        frame_check(8'h01, 1'b1, "R4");
        frame_check(8'h80, 1'b1, "R4");
        frame_check(8'h00, 1'b1, "R5");

        // R5 framing error, data still delivered
        frame_check(8'hA7, 1'b0, "R5");
        frame_check(8'h3C, 1'b1, "R5");

        // R3 three-clock glitch rejected, R9 outputs held
        held = rx_data;
        p0 = pulses;
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        idle(120);
        check(pulses == p0, "R3", pulses - p0, 0);
        check(rx_data == held, "R9", rx_data, held);

        // R3 four-clock glitch accepted as 0xFF
        p0 = pulses;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        idle(120);
        check(pulses == p0 + 1, "R3", pulses - p0, 1);
        check(log_d[p0 % 4] == 8'hFF, "R3", log_d[p0 % 4], 8'hFF);
        check(log_f[p0 % 4] == 1'b0, "R3", log_f[p0 % 4], 0);

        // R7 back to back
        p0 = pulses;
        send(8'hC3, 1'b1);
        send(8'h5A, 1'b1);
        idle(24);
        check(pulses == p0 + 2, "R7", pulses - p0, 2);
        check(log_d[p0 % 4] == 8'hC3, "R7", log_d[p0 % 4], 8'hC3);
        check(log_d[(p0 + 1) % 4] == 8'h5A, "R7", log_d[(p0 + 1) % 4], 8'h5A);

        // R8 disabled receiver ignores a frame
        rx_en = 1'b0;
        p0 = pulses;
        send(8'h12, 1'b1);
        idle(24);
        check(pulses == p0, "R8", pulses - p0, 0);
        rx_en = 1'b1;
        idle(8);

        // R8 enable dropped mid-frame
        p0 = pulses;
        fork
            send(8'h96, 1'b1);
            begin
                repeat (40) @(negedge clk);
                rx_en = 1'b0;
            end
        join
        idle(24);
        check(pulses == p0, "R8", pulses - p0, 0);
        rx_en = 1'b1;
        idle(8);
        frame_check(8'h69, 1'b1, "R8");

        // R4 R5 random frames
        for (int k = 0; k < 24; k++) begin
            logic [7:0] b;
            logic s;
            b = 8'($urandom);
            s = ($urandom % 4) != 0;
            frame_check(b, s, "R4");
        end

        // R6 strobe width over the whole run
        check(wide == 0, "R6", wide, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule